// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block handles a read miss for a pipelined processor's data or instruction cache. On a miss it holds the pipeline and reads the four-word line from a four-bank interleaved memory. The burst starts with the word the processor asked for. Once that word is stored locally, the controller returns it to the pipeline and drops the stall. The remaining three words keep arriving in the background.

While the background fill is running, the controller also answers pipeline reads that fall in the line being filled. A read of a word that has already arrived is answered at once. A read of a word that is still outstanding is held until that word lands. A miss to another line has to wait until the current fill has finished. When all four words are present, the controller writes the complete 128-bit line into the cache array in a single cycle. That write is the point at which the line becomes valid.

Top module: `line_refill`

## Requirements
- R1: A miss (`req_valid` and `req_miss` high) that arrives while no fill is running raises `stall` in the same cycle. In the next cycle the controller requests the bank selected by address bits [3:2], which identify the critical word.
- R2: A fill asks each of the four banks exactly once, one bank per cycle on consecutive cycles, in the order crit, crit+1, crit+2, crit+3 modulo 4. No more than one bit of `bank_req` is ever high. `bank_row` carries the requested address bits [31:4].
- R3: In the cycle after the critical word's response has been captured, `stall` falls and `rdata_valid` rises with that word on `rdata`. This happens before the last word of the line has been received.
- R4: While a fill runs, a non-miss read to a different line is left to the cache: `stall` and `rdata_valid` both stay low.
- R5: A read to a word of the line being filled that has already arrived gets `rdata_valid` with its data and no `stall` in the same cycle.
- R6: A read to a word of the line being filled that has not arrived yet keeps `stall` high until that word has been captured, and is then served with the correct data.
- R7: A miss to a different line during a fill keeps `stall` high until the current line has been written. Its own fill then begins with a request to its critical bank.
- R8: `line_we` pulses for exactly one cycle, and only after all four words have arrived. During that cycle `line_addr` holds the line address, and `line_data` holds word i (address bits [3:2] = i) in bits [32i+31:32i].
- R9: While reset is held, and after it is released with no request pending, `stall`, `rdata_valid`, `line_we` and `bank_req` are all low.
- R10: `stall` and `rdata_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Pipeline read request present |
| req_miss | input | 1 | Cache tag lookup missed for this request |
| req_addr | input | AW | Physical byte address of the request |
| stall | output | 1 | Hold the pipeline |
| rdata_valid | output | 1 | `rdata` answers the current request |
| rdata | output | DW | Word returned to the pipeline |
| bank_req | output | 4 | Read request, one bit per bank |
| bank_row | output | AW-4 | Line address sent to all banks |
| bank_rvalid | input | 4 | Read response valid, one bit per bank |
| bank_rdata | input | 4*DW | Response data, bank b in bits [DW*b+DW-1:DW*b] |
| line_we | output | 1 | Write the complete line into the cache array |
| line_addr | output | AW-4 | Line address of the write |
| line_data | output | 4*DW | Line contents, word i in bits [DW*i+DW-1:DW*i] |

## Verification
The assertions rely on a few properties of the inputs. The pipeline keeps `req_valid`, `req_miss` and `req_addr` steady while `stall` is high. Each bank answers exactly once for each request it receives, and it never answers unless a request is outstanding. The bench contains a fixed-latency memory model that answers every bank request three cycles after it was issued. Its stimulus changes a request only after that request has been served, or to probe a fill that is in progress. Because the model's answers come back in issue order, the critical word is always received first, which lets the bench measure the early release.

// File: rtl/line_refill.sv
module line_refill #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BO = $clog2(DW / 8),
  localparam int LO = BO + 2,
  localparam int RW = AW - LO
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_miss,
  input  logic [AW-1:0]   req_addr,
  output logic            stall,
  output logic            rdata_valid,
  output logic [DW-1:0]   rdata,
  output logic [3:0]      bank_req,
  output logic [RW-1:0]   bank_row,
  input  logic [3:0]      bank_rvalid,
  input  logic [4*DW-1:0] bank_rdata,
  output logic            line_we,
  output logic [RW-1:0]   line_addr,
  output logic [4*DW-1:0] line_data
);

  logic          active;
  logic [RW-1:0] row_q;
  logic [1:0]    crit_q;
  logic [2:0]    icnt;
  logic [3:0]    filled;
  logic [DW-1:0] wbuf [4];

  logic [1:0] rw;
  logic [1:0] issue_b;
  logic       same_line, start, done;

  assign rw        = req_addr[BO+1:BO];
  assign same_line = active && (req_addr[AW-1:LO] == row_q);
  assign start     = !active && req_valid && req_miss;
  assign done      = active && (&filled);
  assign issue_b   = crit_q + icnt[1:0];

  assign bank_req    = (active && !icnt[2]) ? (4'b0001 << issue_b) : 4'b0000;
  assign bank_row    = row_q;
  assign stall       = req_valid && ((req_miss && !same_line) || (same_line && !filled[rw]));
  assign rdata_valid = req_valid && same_line && filled[rw];
  assign rdata       = wbuf[rw];
  assign line_we     = done;
  assign line_addr   = row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      row_q  <= '0;
      crit_q <= '0;
      icnt   <= '0;
      filled <= '0;
    end else if (start) begin
      active <= 1'b1;
      row_q  <= req_addr[AW-1:LO];
      crit_q <= rw;
      icnt   <= '0;
      filled <= '0;
    end else if (active) begin
      if (!icnt[2]) icnt <= icnt + 3'd1;
      filled <= filled | bank_rvalid;
      if (done) active <= 1'b0;
    end
  end

  for (genvar b = 0; b < 4; b++) begin : g_word
    always_ff @(posedge clk)
      if (active && bank_rvalid[b]) wbuf[b] <= bank_rdata[b*DW +: DW];
    assign line_data[b*DW +: DW] = wbuf[b];
  end

  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && rdata_valid));

  // R2
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_req));

  // R2
  wrap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|bank_req) && (|$past(bank_req))) |->
      (bank_req == {$past(bank_req[2:0]), $past(bank_req[3])}));

  // R1
  crit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && req_valid && req_miss) |=>
      (bank_req == (4'b0001 << $past(req_addr[BO+1:BO]))));

  // R8
  line_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_we |=> !line_we);

endmodule

// File: tb/tb_line_refill.sv
`timescale 1ns/100ps
module tb_line_refill;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_miss = 1'b0;
  logic [31:0]  req_addr = '0;
  logic         stall, rdata_valid, line_we;
  logic [31:0]  rdata;
  logic [3:0]   bank_req;
  logic [27:0]  bank_row, line_addr;
  logic [3:0]   bank_rvalid = '0;
  logic [127:0] bank_rdata = '0;
  logic [127:0] line_data;

  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  line_refill dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_miss(req_miss),
    .req_addr(req_addr), .stall(stall), .rdata_valid(rdata_valid), .rdata(rdata),
    .bank_req(bank_req), .bank_row(bank_row), .bank_rvalid(bank_rvalid),
    .bank_rdata(bank_rdata), .line_we(line_we), .line_addr(line_addr),
    .line_data(line_data));

  function automatic logic [31:0] mw(input logic [27:0] row, input logic [1:0] b);
    return {row[13:0], b, 16'h0000} ^ 32'h9E37_79B9 ^ {4'h0, row};
  endfunction

  function automatic logic [127:0] mline(input logic [27:0] row);
    return {mw(row, 2'd3), mw(row, 2'd2), mw(row, 2'd1), mw(row, 2'd0)};
  endfunction

  int          cnt [4] = '{0, 0, 0, 0};
  logic [27:0] rq  [4];
  always @(negedge clk) begin
    for (int b = 0; b < 4; b++) begin
      bank_rvalid[b] = 1'b0;
      if (cnt[b] != 0) begin
        cnt[b] = cnt[b] - 1;
        if (cnt[b] == 0) begin
          bank_rvalid[b] = 1'b1;
          bank_rdata[b*32 +: 32] = mw(rq[b], 2'(b));
        end
      end
      if (bank_req[b]) begin
        cnt[b] = LAT;
        rq[b]  = bank_row;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 20000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic run_miss(input logic [31:0] addr, input logic [1:0] crit);
    logic [27:0] row = addr[31:4];
    int n = 0;
    bit got = 0, we = 0;
    cyc(); req_valid = 1; req_miss = 1; req_addr = addr; #2;
    chk(stall == 1, "R1 stall on miss", stall, 1);
    for (int k = 0; k < 40 && !we; k++) begin
      cyc(); #2;
      if (k == 0) chk(bank_req == (4'b1 << crit), "R1 critical bank first", bank_req, 4'b1 << crit);
      if (bank_req != 0) begin
        chk(bank_req == (4'b1 << 2'(crit + n)), "R2 wrap order", bank_req, 4'b1 << 2'(crit + n));
        chk(bank_row == row, "R2 row", bank_row, row);
        n++;
      end
      chk(!(stall && rdata_valid), "R10 exclusive", {stall, rdata_valid}, 2'b00);
      if (!got && rdata_valid) begin
        chk(rdata == mw(row, crit), "R3 critical data", rdata, mw(row, crit));
        chk(!line_we, "R3 early release", line_we, 0);
        got = 1; req_valid = 0;
      end
      if (line_we) begin
        we = 1;
        chk(line_data == mline(row), "R8 line data", line_data, mline(row));
        chk(line_addr == row, "R8 line addr", line_addr, row);
      end
    end
    chk(n == 4, "R2 four requests", n, 4);
    chk(got, "R3 served", got, 1);
    cyc(); #2;
    chk(!line_we, "R8 single pulse", line_we, 0);
  endtask

  localparam logic [33:0] VEC [4] = '{
    {2'd2, 32'h0000_1248},
    {2'd1, 32'h0000_3A74},
    {2'd0, 32'h0001_0000},
    {2'd3, 32'h00A0_5C3C}
  };

  initial begin
    #3;
    chk(!stall && !rdata_valid && !line_we && bank_req == 0, "R9 in reset",
        {stall, rdata_valid, line_we, bank_req}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc(); #2;
    chk(!stall && !rdata_valid && !line_we && bank_req == 0, "R9 after reset",
        {stall, rdata_valid, line_we, bank_req}, 0);

    foreach (VEC[i]) run_miss(VEC[i][31:0], VEC[i][33:32]);

    // R5 / R6: reads into the line while it fills
    begin
      bit we = 0;
      cyc(); req_valid = 1; req_miss = 1; req_addr = 32'h0000_2224; #2;
      for (int k = 0; k < 20 && !rdata_valid; k++) begin cyc(); #2; end
      chk(rdata_valid && rdata == mw(28'h222, 1), "R3 critical", rdata, mw(28'h222, 1));
      cyc(); req_miss = 0; req_addr = 32'h0000_2224; #2;
      chk(rdata_valid && !stall && rdata == mw(28'h222, 1), "R5 filled word immediate",
          {stall, rdata_valid, rdata}, {2'b01, mw(28'h222, 1)});
      cyc(); req_addr = 32'h0000_2220; #2;
      chk(stall && !rdata_valid, "R6 unfilled word stalls", {stall, rdata_valid}, 2'b10);
      for (int k = 0; k < 20 && stall; k++) begin
        cyc(); #2;
        if (line_we) we = 1;
      end
      chk(rdata_valid && rdata == mw(28'h222, 0), "R6 served after arrival", rdata, mw(28'h222, 0));
      req_valid = 0;
      for (int k = 0; k < 20 && !we; k++) begin cyc(); #2; if (line_we) we = 1; end
    end

    // R4 / R7: unrelated read and second miss during a fill
    begin
      bit we = 0, started = 0;
      cyc(); req_valid = 1; req_miss = 1; req_addr = 32'h0000_4448; #2;
      for (int k = 0; k < 20 && !rdata_valid; k++) begin cyc(); #2; end
      cyc(); req_miss = 0; req_addr = 32'h0000_9990; #2;
      chk(!stall && !rdata_valid, "R4 other line passes", {stall, rdata_valid}, 2'b00);
      cyc(); req_miss = 1; req_addr = 32'h0000_6664; #2;
      for (int k = 0; k < 20 && !we; k++) begin
        chk(stall, "R7 held during fill", stall, 1);
        if (line_we) we = 1; else begin cyc(); #2; end
      end
      for (int k = 0; k < 20 && !rdata_valid; k++) begin
        cyc(); #2;
        if (!started && bank_req != 0) begin
          chk(bank_req == 4'b0010, "R7 new fill critical bank", bank_req, 4'b0010);
          started = 1;
        end
      end
      chk(rdata_valid && rdata == mw(28'h666, 1), "R7 second miss data", rdata, mw(28'h666, 1));
      req_valid = 0;
      we = 0;
      for (int k = 0; k < 20 && !we; k++) begin cyc(); #2; if (line_we) we = 1; end
      chk(we && line_data == mline(28'h666), "R8 second line", line_data, mline(28'h666));
    end

    summary();
  end
endmodule